// File: doc/BRIEF.md
# Unified Memory Port Stall Arbiter

This block sits at the front of a five-stage in-order pipeline whose instruction fetch and data accesses share one single-ported memory. In every cycle it looks at the fetch request and at the load or store presented by the MEM stage. It gives the port to exactly one of them and drives the address, read enable, write enable and write data that the memory sees. The block also owns the program counter and the fetch-to-decode pipeline register.

Data access always wins the port, because the instruction that needs it is the older one. When fetch loses, the PC stays where it is and the decode register receives a bubble instead of an instruction. Each load or store issued while fetch is requesting therefore costs exactly one fetch cycle. Over a run, the cycles in which fetch was requested equal the instructions fetched plus the stalls, so CPI works out to one plus the fraction of instructions that touch data. A stall counter makes that relation visible.

The decision is made in a small state machine. Its state records what happened to the decode register at the last edge: `ST_BOOT` (reset, nothing fetched yet), `ST_FED` (fetch won and delivered a word), `ST_BUBBLE` (fetch lost to a data access) and `ST_IDLE` (nothing was fetched and nothing was lost). The next state depends only on the inputs:
- data request with fetch request → `ST_BUBBLE`
- data request alone → `ST_IDLE`
- fetch request alone → `ST_FED`
- neither → `ST_IDLE`

`ST_BOOT` is entered only through reset. The decode valid bit is high exactly in `ST_FED`.

Top module: `umem_port_arb`

## Requirements
- R1: During and right after reset: the PC equals the reset value (0), the decode instruction, decode PC and stall count are 0, and decode valid is 0.
- R2: When d_rd or d_wr is high, the memory address equals d_addr in the same cycle, whatever f_req is.
- R3: With f_req high and no data request, the memory address equals the PC, mem_re=1, mem_we=0 and mem_wdata=0. At the next edge the decode register takes the returned word and the old PC, decode valid becomes 1, and the PC advances by 4 (DATA_W/8).
- R4: With f_req and a data request in the same cycle, fetch_hold is 1 in that cycle. At the next edge the PC keeps its value, and decode receives instruction 0, PC 0 and valid 0.
- R5: A load (d_rd) and a store (d_wr) both take the port from fetch and both cause the stall. A load drives mem_re=1, mem_we=0. A store drives mem_we=1, mem_re=0 and mem_wdata=d_wdata.
- R6: If d_rd and d_wr are both high, the access is a store: mem_we=1, mem_re=0.
- R7: stall_cnt rises by exactly one at each edge that follows a cycle with fetch_hold=1, and is otherwise unchanged. Over a run, the cycles with f_req high equal the instructions fetched plus stall_cnt.
- R8: With no request at all, mem_re=0, mem_we=0, mem_addr=0 and mem_wdata=0. At the next edge the PC holds, decode gets a bubble, and stall_cnt is unchanged.
- R9: fetch_hold is never 1 unless both f_req and a data request are present. mem_we and mem_re are never both 1.
- R10: Back-to-back data accesses stall fetch in every one of those cycles. Fetch resumes in the first cycle without a data request, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_req | input | 1 | Fetch stage wants an instruction this cycle |
| d_rd | input | 1 | MEM stage load |
| d_wr | input | 1 | MEM stage store |
| d_addr | input | ADDR_W | Byte address of the data access |
| d_wdata | input | DATA_W | Store data |
| mem_rdata | input | DATA_W | Word returned by the memory (same cycle) |
| mem_addr | output | ADDR_W | Address presented to the memory |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| fetch_hold | output | 1 | Fetch lost the port this cycle |
| pc_o | output | ADDR_W | Current program counter |
| id_instr | output | DATA_W | Instruction held in the decode register |
| id_pc | output | ADDR_W | PC of the decode instruction |
| id_valid | output | 1 | Decode register holds a real instruction |
| stall_cnt | output | CNT_W | Number of lost fetch cycles since reset (wraps) |

## Verification
The bench first runs a streak of plain fetches to show that the PC and decode register advance every cycle. It then applies a lone load and a lone store against a requesting fetch, which separates the read and write drive of the port and confirms that both kinds stall. Further directed cases cover a load and store raised together, three data accesses back to back followed by fetch, and a fully idle cycle. The idle case shows that a bubble without contention leaves the stall count alone.

A long seeded random mix of fetch, load and store requests is then checked cycle by cycle against a bench model. At the end, the bench compares the fetch-requested cycles against the fetched instructions plus the stall count.

// File: rtl/umem_arb_pkg.sv
package umem_arb_pkg;

    // What happened to the decode register at the last edge
    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_FED    = 2'd1,
        ST_BUBBLE = 2'd2,
        ST_IDLE   = 2'd3
    } arb_state_t;

    // Owner of the memory port in the current cycle
    typedef enum logic [1:0] {
        GR_NONE  = 2'd0,
        GR_FETCH = 2'd1,
        GR_DATA  = 2'd2
    } grant_t;

endpackage

// File: rtl/umem_arb_fsm.sv
module umem_arb_fsm
    import umem_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_req,
    input  logic              d_rd,
    input  logic              d_wr,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [DATA_W-1:0] d_wdata,
    input  logic [ADDR_W-1:0] pc,
    output grant_t            grant,
    output arb_state_t        state,
    output logic              fetch_hold,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);

    arb_state_t state_q;
    arb_state_t state_d;
    logic       data_req;

    assign data_req = d_rd | d_wr;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Decision: older data access beats fetch
    always_comb begin
        grant      = GR_NONE;
        fetch_hold = 1'b0;
        state_d    = ST_IDLE;
        unique case ({data_req, f_req})
            2'b11: begin
                grant      = GR_DATA;
                fetch_hold = 1'b1;
                state_d    = ST_BUBBLE;
            end
            2'b10: begin
                grant   = GR_DATA;
                state_d = ST_IDLE;
            end
            2'b01: begin
                grant   = GR_FETCH;
                state_d = ST_FED;
            end
            2'b00: begin
                grant   = GR_NONE;
                state_d = ST_IDLE;
            end
        endcase
    end

    // Port drive from the grant
    always_comb begin
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (grant)
            GR_DATA: begin
                mem_addr = d_addr;
                if (d_wr) begin
                    mem_we    = 1'b1;
                    mem_wdata = d_wdata;
                end else begin
                    mem_re = 1'b1;
                end
            end
            GR_FETCH: begin
                mem_addr = pc;
                mem_re   = 1'b1;
            end
            default: begin
                mem_addr = '0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/umem_pc_reg.sv
module umem_pc_reg #(
    parameter int                ADDR_W   = 16,
    parameter int                STEP     = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else if (advance) begin
            pc <= pc + STEP_V;
        end
    end

endmodule

// File: rtl/umem_ifid_reg.sv
module umem_ifid_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] instr_in,
    input  logic [ADDR_W-1:0] pc_in,
    output logic [DATA_W-1:0] instr_q,
    output logic [ADDR_W-1:0] pc_q
);

    // A cycle without a delivered fetch puts an all-zero NOP into decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            pc_q    <= '0;
        end else if (load) begin
            instr_q <= instr_in;
            pc_q    <= pc_in;
        end else begin
            instr_q <= '0;
            pc_q    <= '0;
        end
    end

endmodule

// File: rtl/umem_stall_ctr.sv
module umem_stall_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/umem_port_arb.sv
module umem_port_arb
    import umem_arb_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 32,
    parameter int                CNT_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_req,
    input  logic              d_rd,
    input  logic              d_wr,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [DATA_W-1:0] d_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fetch_hold,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] id_instr,
    output logic [ADDR_W-1:0] id_pc,
    output logic              id_valid,
    output logic [CNT_W-1:0]  stall_cnt
);

    localparam int PC_STEP = DATA_W / 8;

    grant_t     grant;
    arb_state_t state;
    logic       fetch_go;
    logic [ADDR_W-1:0] pc;

    umem_arb_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .f_req      (f_req),
        .d_rd       (d_rd),
        .d_wr       (d_wr),
        .d_addr     (d_addr),
        .d_wdata    (d_wdata),
        .pc         (pc),
        .grant      (grant),
        .state      (state),
        .fetch_hold (fetch_hold),
        .mem_addr   (mem_addr),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata)
    );

    assign fetch_go = (grant == GR_FETCH);

    umem_pc_reg #(
        .ADDR_W   (ADDR_W),
        .STEP     (PC_STEP),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fetch_go),
        .pc      (pc)
    );

    umem_ifid_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ifid (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fetch_go),
        .instr_in (mem_rdata),
        .pc_in    (pc),
        .instr_q  (id_instr),
        .pc_q     (id_pc)
    );

    umem_stall_ctr #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (fetch_hold),
        .count (stall_cnt)
    );

    assign pc_o     = pc;
    assign id_valid = (state == ST_FED);

endmodule

// File: rtl/umem_port_arb_chk.sv
module umem_port_arb_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              f_req,
    input logic              d_rd,
    input logic              d_wr,
    input logic [ADDR_W-1:0] d_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re,
    input logic              mem_we,
    input logic              fetch_hold,
    input logic [ADDR_W-1:0] pc_o,
    input logic [DATA_W-1:0] id_instr,
    input logic              id_valid,
    input logic [CNT_W-1:0]  stall_cnt
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(DATA_W / 8);

    a_r2_data_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rd || d_wr) |-> (mem_addr == d_addr));

    a_r3_fetch_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (f_req && !d_rd && !d_wr) |=> (id_valid && pc_o == $past(pc_o) + STEP_V));

    a_r4_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (f_req && (d_rd || d_wr)) |=> (pc_o == $past(pc_o)));

    a_r4_bubble_in: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold |=> (!id_valid && id_instr == '0));

    a_r6_store_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rd && d_wr) |-> (mem_we && !mem_re));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold |=> (stall_cnt == $past(stall_cnt) + 1'b1));

    a_r7_count_still: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_hold |=> $stable(stall_cnt));

    a_r9_hold_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold |-> (f_req && (d_rd || d_wr)));

    a_r9_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

endmodule

bind umem_port_arb umem_port_arb_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .f_req      (f_req),
    .d_rd       (d_rd),
    .d_wr       (d_wr),
    .d_addr     (d_addr),
    .mem_addr   (mem_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .fetch_hold (fetch_hold),
    .pc_o       (pc_o),
    .id_instr   (id_instr),
    .id_valid   (id_valid),
    .stall_cnt  (stall_cnt)
);

// File: tb/sim_umem_port_arb.sv
module sim_umem_port_arb;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          f_req, d_rd, d_wr;
    logic [AW-1:0] d_addr;
    logic [DW-1:0] d_wdata;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_re, mem_we;
    logic [DW-1:0] mem_wdata;
    logic          fetch_hold;
    logic [AW-1:0] pc_o;
    logic [DW-1:0] id_instr;
    logic [AW-1:0] id_pc;
    logic          id_valid;
    logic [CW-1:0] stall_cnt;

    int n_vec = 0;
    int n_bad = 0;

    logic [DW-1:0] mem [0:255];

    // Bench model state
    logic [AW-1:0] m_pc;
    logic [DW-1:0] m_instr;
    logic [AW-1:0] m_idpc;
    logic          m_valid;
    int            m_stall;
    int            freq_cycles;

    always #4 clk = ~clk;

    umem_port_arb #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .f_req(f_req), .d_rd(d_rd), .d_wr(d_wr),
        .d_addr(d_addr), .d_wdata(d_wdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .fetch_hold(fetch_hold), .pc_o(pc_o),
        .id_instr(id_instr), .id_pc(id_pc), .id_valid(id_valid),
        .stall_cnt(stall_cnt)
    );

    // Behavioural single-ported memory, combinational read
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        if (rst_n && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input bit f, input bit r, input bit w,
                                               input logic [AW-1:0] a, input logic [AW-1:0] pc);
        if (r || w) return a;
        if (f) return pc;
        return '0;
    endfunction

    // One cycle: drive, check port, clock, check registers
    task automatic step(input bit f, input bit r, input bit w,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
        logic [AW-1:0] ea;
        logic          ere, ewe, ehold;
        logic [DW-1:0] ewd, fword;
        @(negedge clk);
        f_req = f; d_rd = r; d_wr = w; d_addr = a; d_wdata = wd;
        #1;
        ea    = exp_addr(f, r, w, a, m_pc);
        ewe   = w;
        ere   = (r && !w) || (!r && !w && f);
        ewd   = w ? wd : '0;
        ehold = f && (r || w);
        fword = mem[m_pc[9:2]];
        chk(mem_addr == ea, {tag, " R2/R3 addr"}, 64'(mem_addr), 64'(ea));
        chk(mem_re == ere && mem_we == ewe, {tag, " R5/R6/R9 re,we"},
            64'({mem_re, mem_we}), 64'({ere, ewe}));
        chk(mem_wdata == ewd, {tag, " R5 wdata"}, 64'(mem_wdata), 64'(ewd));
        chk(fetch_hold == ehold, {tag, " R4/R9 hold"}, 64'(fetch_hold), 64'(ehold));
        if (f) freq_cycles++;
        if (r || w) begin
            if (f) m_stall++;
            m_instr = '0; m_idpc = '0; m_valid = 1'b0;
        end else if (f) begin
            m_instr = fword; m_idpc = m_pc; m_valid = 1'b1;
            m_pc = m_pc + AW'(4);
        end else begin
            m_instr = '0; m_idpc = '0; m_valid = 1'b0;
        end
        @(posedge clk);
        #2;
        chk(pc_o == m_pc, {tag, " R3/R4/R8 pc"}, 64'(pc_o), 64'(m_pc));
        chk(id_instr == m_instr && id_pc == m_idpc && id_valid == m_valid,
            {tag, " R3/R4 decode"}, {id_valid, id_pc, id_instr}, {m_valid, m_idpc, m_instr});
        chk(stall_cnt == CW'(m_stall), {tag, " R7 stall count"},
            64'(stall_cnt), 64'(m_stall));
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 ^ (i * 32'h00010203);
        rst_n = 1'b0; f_req = 0; d_rd = 0; d_wr = 0; d_addr = '0; d_wdata = '0;
        m_pc = '0; m_instr = '0; m_idpc = '0; m_valid = 0; m_stall = 0; freq_cycles = 0;
        repeat (3) @(posedge clk);
        #2;
        chk(pc_o == '0 && id_instr == '0 && id_pc == '0 && !id_valid && stall_cnt == '0,
            "R1 reset state", {pc_o, id_valid, stall_cnt}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(pc_o == '0 && !id_valid && !mem_re && !mem_we, "R1 after release",
            {pc_o, id_valid, mem_re, mem_we}, 64'd0);

        // R3: fetch streak
        for (int i = 0; i < 5; i++) step(1, 0, 0, '0, '0, "R3 fetch run");
        // R5: load then store against fetch
        step(1, 1, 0, 16'h0040, '0, "R5 load conflict");
        step(1, 0, 0, '0, '0, "R3 resume");
        step(1, 0, 1, 16'h0018, 32'hDEADBEEF, "R5 store conflict");
        // R6: both strobes high
        step(1, 1, 1, 16'h0020, 32'h12345678, "R6 rd+wr");
        // R10: back-to-back data, then fetch resumes at once
        step(1, 1, 0, 16'h0100, '0, "R10 b2b 1");
        step(1, 0, 1, 16'h0104, 32'hA5A5A5A5, "R10 b2b 2");
        step(1, 1, 0, 16'h0104, '0, "R10 b2b 3");
        step(1, 0, 0, '0, '0, "R10 resume");
        // R8: idle cycles and data without fetch
        step(0, 0, 0, '0, '0, "R8 idle");
        step(0, 1, 0, 16'h0008, '0, "R8 data no fetch");
        step(1, 0, 0, '0, '0, "R3 fetch after idle");

        // Constrained random mix
        begin
            logic [AW-1:0] pc0;
            int st0, fq0;
            void'($urandom(32'd20240611));
            pc0 = m_pc; st0 = m_stall; fq0 = freq_cycles;
            for (int i = 0; i < 3000; i++) begin
                int sel;
                bit f, r, w;
                sel = int'($urandom % 10);
                f = ($urandom % 8) != 0;
                r = (sel < 2);
                w = (sel == 2) || (sel == 3 && ($urandom % 4) == 0);
                step(f, r, w, {6'b0, 8'($urandom), 2'b00}, $urandom, "R2 random");
            end
            // R7: fetch-requested cycles = fetched words + stalls
            chk(int'((m_pc - pc0) >> 2) + (m_stall - st0) == (freq_cycles - fq0),
                "R7 CPI relation", 64'(int'((pc_o - pc0) >> 2) + int'(stall_cnt) - st0),
                64'(freq_cycles - fq0));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule